// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 1M x 8 words. The host issues one word at a time over a valid/ready handshake, with a write flag, a 20-bit address and 8-bit write data. Reads return their byte with a one-cycle response pulse. On the memory side the controller drives the address, a low-true and a high-true chip enable, a low-true write strobe and a low-true output enable. It also drives a split data bus (outgoing byte, incoming byte, drive enable) that a pad ring joins into bidirectional pins.

The RAM has no clock, so every interval it needs is counted out in controller cycles. Each minimum (access time, output-enable-to-data time, strobe width, data setup, address-to-strobe-end time, cycle time and bus release after output enable) is a parameter in nanoseconds. It is converted to a cycle count by rounding up against a clock-period parameter. A Moore state machine with five states walks each access. ST_IDLE accepts a request (transition ACCEPT_RD or ACCEPT_WR). ST_RD_WAIT holds the read strobes until the access count runs out (RD_DONE, which captures the byte). ST_WR_TURN waits until the data pins have been released long enough after the last read (BUS_FREE). ST_WR_PULSE holds the write strobe low (PULSE_DONE). ST_WR_HOLD keeps the data driven with the strobe high and pads the write cycle (HOLD_DONE back to ST_IDLE). While idle the RAM is deselected and left in standby.

Top module: `sram_async_ctrl`

## Requirements
- R1: In ST_IDLE the chip is deselected (mem_ce_n = 1, mem_ce = 0) and req_ready = 1. During every access both enables are active (mem_ce_n = 0, mem_ce = 1). After reset the block is idle with mem_we_n = 1, mem_oe_n = 1, mem_dq_oe = 0 and rsp_valid = 0.
- R2: During a read, mem_we_n = 1, mem_oe_n = 0 and mem_dq_oe = 0. The write strobe and the output enable are never low together.
- R3: A read returns the byte most recently written to that address. The byte is captured from mem_dq_in at the last edge of the read window, and no earlier than the access time after the address and no earlier than the output-enable time after mem_oe_n falls.
- R4: The write strobe stays low for PULSE_CYC cycles, the largest of the rounded-up strobe width, data setup and address-to-strobe-end minimums. Throughout that time the enables are active, mem_dq_oe = 1 and mem_dq_out is stable.
- R5: mem_addr changes only when a request is accepted, and mem_we_n is high in the cycles on both sides of any change.
- R6: For one cycle after mem_we_n rises, mem_dq_oe stays 1 with the same data.
- R7: mem_dq_oe rises only after mem_oe_n has been high for at least TURN_CYC full cycles (rounded-up release time), and mem_dq_oe = 1 never coincides with mem_oe_n = 0.
- R8: Between two changes of mem_addr at least the read or write cycle minimum elapses.
- R9: req_ready is 1 only in ST_IDLE, and a request is taken when req_valid and req_ready are both 1. rsp_valid is a one-cycle pulse issued only for reads, RD_CYC + 1 negative clock edges after acceptance (RD_CYC being the largest rounded-up read minimum). RD_CYC = 6 at a 10 ns clock.
- R10: A write accepted with the bus already released returns to ready after 1 + PULSE_CYC + HOLD_CYC cycles (7 negative edges counted as for R9 at a 10 ns clock). A write that follows a read waits at most TURN_CYC + 1 further cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, low true |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle pulse: rsp_rdata holds read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 20 | Address to the RAM |
| mem_ce_n | output | 1 | Low-true chip enable |
| mem_ce | output | 1 | High-true chip enable |
| mem_we_n | output | 1 | Low-true write strobe |
| mem_oe_n | output | 1 | Low-true output enable |
| mem_dq_out | output | 8 | Byte driven toward the data pins |
| mem_dq_in | input | 8 | Byte received from the data pins |
| mem_dq_oe | output | 1 | 1 = controller drives the data pins |

## Verification
A state register stuck or skipping ahead shows within one cycle as a wrong strobe combination at the memory pins. Examples are an enable still active while ready is high, or a data drive coinciding with output enable. A wrong timer load shows at the end of the access as a strobe edge too early, measured in nanoseconds by the attached RAM model. An early read capture returns the inverted stale byte that the model presents before access time, and this is visible in the returned data of that same access. A bus-release counter that frees the bus too soon shows as data driven less than the release time after output enable rose, on the first write that follows a read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RD_WAIT  = 3'd1,
        ST_WR_TURN  = 3'd2,
        ST_WR_PULSE = 3'd3,
        ST_WR_HOLD  = 3'd4
    } ctrl_state_e;

    // nanoseconds to whole clock cycles, rounded up, never below one
    function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                              input int unsigned period);
        int unsigned c;
        c = (ns + period - 1) / period;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned umax(input int unsigned a,
                                         input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_step_timer.sv
module sram_step_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_bus_release.sv
module sram_bus_release #(
    parameter int unsigned TURN_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic bus_free
);

    localparam int unsigned W = $clog2(TURN_CYC + 1);
    localparam logic [W-1:0] TURN_V = W'(TURN_CYC);

    logic [W-1:0] hi_cnt_q;

    // counts cycles with output enable released, saturating at TURN_V
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt_q <= TURN_V;
        end else if (!oe_n) begin
            hi_cnt_q <= '0;
        end else if (hi_cnt_q < TURN_V) begin
            hi_cnt_q <= hi_cnt_q + 1'b1;
        end
    end

    assign bus_free = (hi_cnt_q >= TURN_V);

endmodule

// File: rtl/sram_xfer_regs.sv
module sram_xfer_regs #(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] rdata_q,
    output logic              rvalid_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= capture;
            if (capture) begin
                rdata_q <= mem_dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_RC_NS       = 55,
    parameter int unsigned T_AA_NS       = 55,
    parameter int unsigned T_OE_NS       = 30,
    parameter int unsigned T_WC_NS       = 55,
    parameter int unsigned T_WP_NS       = 30,
    parameter int unsigned T_AW_NS       = 40,
    parameter int unsigned T_DW_NS       = 25,
    parameter int unsigned T_OHZ_NS      = 25
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_ce,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    // read window: access, output-enable and cycle minimums
    localparam int unsigned RD_CYC = umax(umax(ns_to_cyc(T_AA_NS, CLK_PERIOD_NS),
                                               ns_to_cyc(T_OE_NS, CLK_PERIOD_NS)),
                                          ns_to_cyc(T_RC_NS, CLK_PERIOD_NS));
    // write strobe: width, data setup, address-to-end minimums
    localparam int unsigned PULSE_CYC = umax(umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                                  ns_to_cyc(T_DW_NS, CLK_PERIOD_NS)),
                                             ns_to_cyc(T_AW_NS, CLK_PERIOD_NS));
    localparam int unsigned WC_CYC    = ns_to_cyc(T_WC_NS, CLK_PERIOD_NS);
    // one turn cycle and one idle cycle always precede the next address change
    localparam int unsigned HOLD_CYC  = (WC_CYC > PULSE_CYC + 2) ?
                                        (WC_CYC - PULSE_CYC - 2) : 1;
    localparam int unsigned TURN_CYC  = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int unsigned CNT_MAX   = umax(umax(RD_CYC, PULSE_CYC), HOLD_CYC);
    localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

    localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] PULSE_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LD  = CNT_W'(HOLD_CYC - 1);

    ctrl_state_e      state_q;
    ctrl_state_e      state_d;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             bus_free;
    logic             accept;
    logic             capture;

    sram_step_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_bus_release #(
        .TURN_CYC (TURN_CYC)
    ) release_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (mem_oe_n),
        .bus_free (bus_free)
    );

    sram_xfer_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .capture   (capture),
        .mem_dq_in (mem_dq_in),
        .addr_q    (mem_addr),
        .wdata_q   (mem_dq_out),
        .rdata_q   (rsp_rdata),
        .rvalid_q  (rsp_valid)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions: ACCEPT_RD, ACCEPT_WR, RD_DONE, BUS_FREE, PULSE_DONE, HOLD_DONE
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WR_TURN;
                    end else begin
                        state_d  = ST_RD_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LD;
                    end
                end
            end
            ST_RD_WAIT: begin
                if (tmr_expired) begin
                    capture = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WR_TURN: begin
                if (bus_free) begin
                    state_d  = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LD;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_expired) begin
                    state_d  = ST_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = HOLD_LD;
                end
            end
            ST_WR_HOLD: begin
                if (tmr_expired) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Moore outputs
    always_comb begin
        req_ready = 1'b0;
        mem_ce_n  = 1'b0;
        mem_ce    = 1'b1;
        mem_we_n  = 1'b1;
        mem_oe_n  = 1'b1;
        mem_dq_oe = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                mem_ce_n  = 1'b1;
                mem_ce    = 1'b0;
            end
            ST_RD_WAIT: begin
                mem_oe_n = 1'b0;
            end
            ST_WR_TURN: begin
                mem_oe_n = 1'b1;
            end
            ST_WR_PULSE: begin
                mem_we_n  = 1'b0;
                mem_dq_oe = 1'b1;
            end
            ST_WR_HOLD: begin
                mem_dq_oe = 1'b1;
            end
            default: begin
                mem_ce_n = 1'b1;
                mem_ce   = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 20,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int unsigned T_OHZ_NS      = 25
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ce_n,
    input logic              mem_ce,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_oe
);

    localparam int unsigned TURN_CYC = ns_to_cyc(T_OHZ_NS, CLK_PERIOD_NS);
    localparam int unsigned W        = $clog2(TURN_CYC + 1);
    localparam logic [W-1:0] TURN_V  = W'(TURN_CYC);

    logic [W-1:0] oe_hi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe_hi_q <= TURN_V;
        end else if (!mem_oe_n) begin
            oe_hi_q <= '0;
        end else if (oe_hi_q < TURN_V) begin
            oe_hi_q <= oe_hi_q + 1'b1;
        end
    end

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_ce)); // R1
    AST_BUSY_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_oe_n || !mem_we_n || mem_dq_oe) |-> (!mem_ce_n && mem_ce && !req_ready)); // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> mem_we_n); // R2
    AST_PULSE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe); // R4
    AST_PULSE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> $stable(mem_dq_out)); // R4
    AST_ADDR_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_addr) |-> (mem_we_n && $past(mem_we_n))); // R5
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out))); // R6
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R7
    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (oe_hi_q >= TURN_V)); // R7
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R9

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .CLK_PERIOD_NS (CLK_PERIOD_NS),
    .T_OHZ_NS      (T_OHZ_NS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .mem_addr   (mem_addr),
    .mem_ce_n   (mem_ce_n),
    .mem_ce     (mem_ce),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe)
);

// File: tb/sram_async_ctrl_tb.sv
module sram_async_ctrl_tb_top;

    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [19:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic [19:0] mem_addr;
    logic        mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(PER/2) clk = ~clk;

    sram_async_ctrl #(
        .CLK_PERIOD_NS (PER)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce     (mem_ce),
        .mem_we_n   (mem_we_n),
        .mem_oe_n   (mem_oe_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_in  (mem_dq_in),
        .mem_dq_oe  (mem_dq_oe)
    );

    // ---------------- expected timing from the requirements ----------------
    function automatic int cyc(input int ns);
        return (ns + PER - 1) / PER;
    endfunction
    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
    function automatic int exp_rd_n();
        return imax(imax(cyc(55), cyc(30)), cyc(55)) + 1;
    endfunction
    function automatic int exp_wr_n();
        int p, h;
        p = imax(imax(cyc(30), cyc(25)), cyc(40));
        h = (cyc(55) > p + 2) ? cyc(55) - p - 2 : 1;
        return 1 + p + h + 1;
    endfunction
    function automatic logic [7:0] fill_val(input logic [19:0] a);
        return a[7:0] ^ a[15:8] ^ {4'h0, a[19:16]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    // ---------------- RAM model with timing monitors ----------------
    logic [7:0] sram_arr [logic [19:0]];
    logic [7:0] exp_arr  [logic [19:0]];
    longint t_addr = -1000, t_oe_fall = -1000, t_oe_rise = -1000;
    longint t_we_fall = -1000, t_dvalid = -1000;
    bit     addr_seen = 1'b0;

    function automatic logic [7:0] sram_get(input logic [19:0] a);
        if (sram_arr.exists(a)) return sram_arr[a];
        return fill_val(a);
    endfunction

    always @(mem_addr) begin
        if (rst_n) begin
            chk(mem_we_n === 1'b1, "R5", "we_n at address change", mem_we_n, 1);
            if (addr_seen)
                chk($time - t_addr >= 55, "R8", "ns between address changes",
                    $time - t_addr, 55);
            addr_seen = 1'b1;
        end
        t_addr = $time;
    end
    always @(negedge mem_oe_n) t_oe_fall = $time;
    always @(posedge mem_oe_n) t_oe_rise = $time;
    always @(negedge mem_we_n) t_we_fall = $time;
    always @(mem_dq_out or posedge mem_dq_oe) t_dvalid = $time;

    always @(posedge mem_dq_oe) begin
        if (rst_n) begin
            chk(mem_oe_n === 1'b1, "R7", "oe_n while driving", mem_oe_n, 1);
            chk($time - t_oe_rise >= 25, "R7", "ns from oe_n rise to drive",
                $time - t_oe_rise, 25);
        end
    end

    always @(posedge mem_we_n) begin
        if (rst_n && mem_ce_n === 1'b0 && mem_ce === 1'b1) begin
            chk($time - t_we_fall >= 30, "R4", "write strobe ns", $time - t_we_fall, 30);
            chk($time - t_dvalid >= 25, "R4", "data setup ns", $time - t_dvalid, 25);
            chk($time - t_addr >= 40, "R4", "address to strobe end ns", $time - t_addr, 40);
            chk(mem_dq_oe === 1'b1, "R4", "drive at strobe end", mem_dq_oe, 1);
            sram_arr[mem_addr] = mem_dq_out;
        end
    end

    // read data: stale (inverted) until access and output-enable times pass
    always @(negedge clk) begin
        if (mem_ce_n === 1'b0 && mem_ce === 1'b1 && mem_we_n === 1'b1 &&
            mem_oe_n === 1'b0) begin
            if ($time - t_addr >= 55 && $time - t_oe_fall >= 30)
                mem_dq_in = sram_get(mem_addr);
            else
                mem_dq_in = ~sram_get(mem_addr);
        end else begin
            mem_dq_in = 8'h00;
        end
    end

    // ---------------- host tasks (called at a negedge) ----------------
    task automatic do_write(input logic [19:0] a, input logic [7:0] d, output int n);
        logic prev_we;
        bit   saw_rsp;
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready === 1'b0, "R9", "ready while writing", req_ready, 0);
        chk(mem_ce_n === 1'b0 && mem_ce === 1'b1, "R1", "enables during write",
            {mem_ce_n, mem_ce}, 1);
        n = 1; prev_we = mem_we_n; saw_rsp = 1'b0;
        forever begin
            if (prev_we === 1'b0 && mem_we_n === 1'b1)
                chk(mem_dq_oe === 1'b1, "R6", "drive after strobe rise", mem_dq_oe, 1);
            prev_we = mem_we_n;
            if (rsp_valid === 1'b1) saw_rsp = 1'b1;
            if (req_ready === 1'b1) break;
            @(negedge clk);
            n++;
        end
        chk(!saw_rsp, "R9", "response pulse on write", saw_rsp, 0);
        chk(mem_ce_n === 1'b1 && mem_ce === 1'b0, "R1", "deselected after write",
            {mem_ce_n, mem_ce}, 2);
        exp_arr[a] = d;
    endtask

    task automatic do_read(input logic [19:0] a, output int n, output logic [7:0] q);
        while (req_ready !== 1'b1) @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(mem_we_n === 1'b1 && mem_oe_n === 1'b0 && mem_dq_oe === 1'b0, "R2",
            "read strobes we/oe/drive", {mem_we_n, mem_oe_n, mem_dq_oe}, 4);
        chk(mem_ce_n === 1'b0 && mem_ce === 1'b1 && req_ready === 1'b0, "R1",
            "enables during read", {mem_ce_n, mem_ce, req_ready}, 2);
        n = 1;
        while (rsp_valid !== 1'b1 && n < 100) begin
            @(negedge clk);
            n++;
        end
        q = rsp_rdata;
    endtask

    function automatic logic [7:0] exp_get(input logic [19:0] a);
        if (exp_arr.exists(a)) return exp_arr[a];
        return fill_val(a);
    endfunction

    task automatic read_check(input logic [19:0] a, input string tag);
        int n;
        logic [7:0] q;
        do_read(a, n, q);
        chk(n == exp_rd_n(), "R9", "read response edge count", n, exp_rd_n());
        chk(q === exp_get(a), "R3", tag, q, exp_get(a));
    endtask

    // ---------------- stimulus ----------------
    initial begin
        int n;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
        chk(mem_ce_n === 1'b1 && mem_ce === 1'b0, "R1", "deselected after reset",
            {mem_ce_n, mem_ce}, 2);
        chk(mem_we_n === 1'b1 && mem_oe_n === 1'b1 && mem_dq_oe === 1'b0 &&
            rsp_valid === 1'b0, "R1", "strobes idle after reset",
            {mem_we_n, mem_oe_n, mem_dq_oe, rsp_valid}, 12);

        // corners: lowest and highest address, unwritten address
        read_check(20'h00123, "unwritten read");
        repeat (5) @(negedge clk);
        do_write(20'h00000, 8'h3C, n);
        chk(n == exp_wr_n(), "R10", "write from idle edge count", n, exp_wr_n());
        read_check(20'h00000, "read address zero");
        do_write(20'hFFFFF, 8'hC3, n);     // write right after read
        chk(n >= exp_wr_n() && n <= exp_wr_n() + cyc(25) + 1, "R10",
            "write after read edge count", n, exp_wr_n());
        read_check(20'hFFFFF, "read top address");
        do_write(20'h5A5A5, 8'h11, n);
        do_write(20'h5A5A5, 8'hEE, n);     // overwrite
        read_check(20'h5A5A5, "read after overwrite");
        read_check(20'h5A5A5, "back to back read");

        // constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [19:0] a;
            logic [7:0]  d;
            case ($urandom % 4)
                0: a = 20'h00000;
                1: a = 20'hFFFFF;
                2: a = 20'h40000 + 20'($urandom % 16);
                default: a = 20'($urandom);
            endcase
            d = 8'($urandom);
            repeat ($urandom % 3) @(negedge clk);
            if ($urandom % 2) begin
                do_write(a, d, n);
                chk(n >= exp_wr_n() && n <= exp_wr_n() + cyc(25) + 1, "R10",
                    "random write edge count", n, exp_wr_n());
            end else begin
                read_check(a, "random read");
            end
        end
        repeat (4) @(negedge clk);
        finish_run();
    end

    initial begin
        #(PER * 150000);
        n_checks++;
        n_errors++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

endmodule